// File: doc/BRIEF.md
# Streaming Character Sequence Spotter

This block watches a stream of 8-bit ASCII characters that arrives one byte per clock. A strobe marks the cycles that carry a character. The block raises a one-bit hit flag when the five most recent accepted characters spell a fixed sequence. That sequence is a parameter, and by default it is A, B, A, A, B in arrival order.

Four byte registers keep the characters that came before the newest one. The newest character is compared directly from the input port. Because of this, the hit flag is combinational on the current input and rises in the same cycle as the final character of the sequence.

Matches may overlap, because the history is a sliding window. Bytes other than 'A' and 'B' move through the window like any other byte, and they simply fail the comparison.

Top module: `seq_spotter`

## Requirements
- R1: `hit` rises in the same cycle in which the final character of the sequence is presented with `chr_vld` high, with no register between the input port and the flag.
- R2: With the default parameter the sequence is 0x41, 0x42, 0x41, 0x41, 0x42 ('A','B','A','A','B'), oldest first. Any other five-character window leaves `hit` low.
- R3: The history advances only in cycles where `chr_vld` is high. Idle cycles inserted anywhere inside a sequence do not stop it from matching.
- R4: `hit` is low in every cycle where `chr_vld` is low, whatever the history holds.
- R5: Reset is synchronous and active high. It clears all four history bytes to 0x00, so a partial sequence received before reset cannot complete after it.
- R6: After reset, `hit` stays low until at least four characters have been accepted.
- R7: Overlapping occurrences are detected. In the stream ABAABAAB, `hit` is high on the 5th and the 8th accepted characters.
- R8: Bytes other than 0x41 and 0x42 (for example 0x61) are shifted into the history and make every window that contains them fail. The block has no error output.
- R9: The sequence is a parameter `PATTERN` of five bytes. Its most significant byte is the oldest character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chr_vld | input | 1 | High in cycles that carry a character |
| chr_data | input | 8 | ASCII character byte |
| hit | output | 1 | High when the newest accepted character completes the sequence |

## Verification
The only result, `hit`, is due in the same cycle as its stimulus. The bench therefore drives each character just after a falling edge and samples `hit` one time unit later, before the next rising edge. The history shift that the character causes is checked one cycle later, through the `hit` value produced by the following character.

The bench keeps its own window of accepted bytes and recomputes the expected flag for every driven cycle. It runs an exhaustive sweep of all 32 five-letter A/B words, each after a reset, followed by a long mixed stream with idle cycles and foreign bytes.

// File: rtl/seq_spotter_pkg.sv
package seq_spotter_pkg;

    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    localparam char_t CH_A    = 8'h41;
    localparam char_t CH_B    = 8'h42;
    localparam char_t CH_NONE = 8'h00;

    // One input beat: strobe plus byte
    typedef struct packed {
        logic  vld;
        char_t data;
    } beat_t;

    // Pick character k of a packed pattern, k = 0 being the newest (LSB byte)
    function automatic char_t pat_byte(input logic [63:0] pat, input int k);
        return pat[k*CHAR_W +: CHAR_W];
    endfunction

endpackage

// File: rtl/seq_history.sv
module seq_history
    import seq_spotter_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  beat_t                   beat,
    output logic [DEPTH-1:0][CHAR_W-1:0] hist_q
);

    // Stage 0 holds the most recently accepted byte, stage DEPTH-1 the oldest
    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q[s] <= CH_NONE;
                end else if (beat.vld) begin
                    if (s == 0) begin
                        hist_q[s] <= beat.data;
                    end else begin
                        hist_q[s] <= hist_q[(s > 0) ? s-1 : 0];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/seq_compare.sv
module seq_compare
    import seq_spotter_pkg::*;
#(
    parameter int                      PAT_LEN = 5,
    parameter logic [PAT_LEN*8-1:0]    PATTERN = "ABAAB",
    localparam int                     HDEPTH  = PAT_LEN - 1
) (
    input  char_t                          live,
    input  logic [HDEPTH-1:0][CHAR_W-1:0]  hist,
    output logic [PAT_LEN-1:0]             eq
);

    localparam logic [63:0] PAT_EXT = 64'(PATTERN);

    // Position 0 compares the live byte; position i+1 compares history stage i
    assign eq[0] = (live == pat_byte(PAT_EXT, 0));

    genvar i;
    generate
        for (i = 0; i < HDEPTH; i++) begin : g_cmp
            assign eq[i+1] = (hist[i] == pat_byte(PAT_EXT, i+1));
        end
    endgenerate

endmodule

// File: rtl/seq_spotter.sv
module seq_spotter
    import seq_spotter_pkg::*;
#(
    parameter int                   PAT_LEN = 5,
    parameter logic [PAT_LEN*8-1:0] PATTERN = "ABAAB"
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chr_vld,
    input  logic [7:0] chr_data,
    output logic       hit
);

    localparam int HDEPTH = PAT_LEN - 1;

    beat_t                          beat;
    logic [HDEPTH-1:0][CHAR_W-1:0]  hist_q;
    logic [PAT_LEN-1:0]             eq;

    assign beat.vld  = chr_vld;
    assign beat.data = chr_data;

    seq_history #(.DEPTH(HDEPTH)) history_i (
        .clk    (clk),
        .rst    (rst),
        .beat   (beat),
        .hist_q (hist_q)
    );

    seq_compare #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) compare_i (
        .live (chr_data),
        .hist (hist_q),
        .eq   (eq)
    );

    assign hit = beat.vld & (&eq);

endmodule

// File: rtl/seq_spotter_chk.sv
module seq_spotter_chk #(
    parameter int                   PAT_LEN = 5,
    parameter logic [PAT_LEN*8-1:0] PATTERN = "ABAAB"
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       chr_vld,
    input logic [7:0]                 chr_data,
    input logic                       hit,
    input logic [(PAT_LEN-1)*8-1:0]   hist_flat
);

    logic [2:0] acc_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt <= '0;
        end else if (chr_vld && acc_cnt != 3'd4) begin
            acc_cnt <= acc_cnt + 3'd1;
        end
    end

    // R4: no flag without a strobe
    a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !chr_vld |-> !hit);

    // R1: the flag is tied to the live byte being the final pattern character
    a_r1_live_last_char: assert property (@(posedge clk) disable iff (rst)
        hit |-> chr_data == PATTERN[7:0]);

    // R3: idle cycle leaves the history untouched
    a_r3_hold_on_idle: assert property (@(posedge clk) disable iff (rst)
        !chr_vld |=> $stable(hist_flat));

    // R3: accepted byte enters the newest stage
    a_r3_shift_in: assert property (@(posedge clk) disable iff (rst)
        chr_vld |=> hist_flat[7:0] == $past(chr_data));

    // R5: history is cleared by reset
    a_r5_cleared: assert property (@(posedge clk)
        rst |=> hist_flat == '0);

    // R6: no flag before four bytes have been accepted
    a_r6_no_early_hit: assert property (@(posedge clk) disable iff (rst)
        hit |-> acc_cnt == 3'd4);

endmodule

bind seq_spotter seq_spotter_chk #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .chr_vld   (chr_vld),
    .chr_data  (chr_data),
    .hit       (hit),
    .hist_flat (hist_q)
);

// File: tb/seq_spotter_tb_top.sv
module seq_spotter_tb_top;

    localparam logic [39:0] PAT = "ABAAB";

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chr_vld = 1'b0;
    logic [7:0] chr_data = 8'h00;
    logic       hit;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] win [4];   // bench window, win[0] newest accepted
    int         acc;       // accepted since reset

    always #2.5 clk = ~clk;   // 200 MHz

    seq_spotter dut_i (
        .clk      (clk),
        .rst      (rst),
        .chr_vld  (chr_vld),
        .chr_data (chr_data),
        .hit      (hit)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic model_hit(logic v, logic [7:0] d);
        logic ok;
        ok = v && (acc >= 4) && (d == PAT[7:0]);
        for (int i = 0; i < 4; i++)
            if (win[i] != PAT[(i+1)*8 +: 8]) ok = 0;
        return ok;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: actual hit=%b expected hit=%b", tag, cyc, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; chr_vld = 1'b0; chr_data = 8'h00;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) win[i] = 8'h00;
        acc = 0;
    endtask

    // drive one cycle, check the same-cycle flag, update the bench window
    task automatic step(logic v, logic [7:0] d, string tag);
        @(negedge clk);
        chr_vld = v; chr_data = d;
        #1;
        check(tag, hit, model_hit(v, d));
        if (v) begin
            for (int i = 3; i > 0; i--) win[i] = win[i-1];
            win[0] = d;
            acc++;
        end
    endtask

    task automatic step_exp(logic v, logic [7:0] d, logic exp, string tag);
        @(negedge clk);
        chr_vld = v; chr_data = d;
        #1;
        check(tag, hit, exp);
        if (v) begin
            for (int i = 3; i > 0; i--) win[i] = win[i-1];
            win[0] = d;
            acc++;
        end
    endtask

    logic [15:0] lfsr;

    initial begin
        acc = 0;
        for (int i = 0; i < 4; i++) win[i] = 8'h00;
        do_reset();
        // R5: reset state, flag low
        step_exp(1'b0, 8'h00, 1'b0, "R5 reset state");

        // R2 R1 R6: exhaustive sweep of five-letter A/B words; only 01001 (ABAAB) hits
        for (int w = 0; w < 32; w++) begin
            do_reset();
            for (int k = 0; k < 5; k++) begin
                logic [7:0] c;
                logic e;
                c = w[4-k] ? 8'h42 : 8'h41;
                e = (k == 4) && (w == 5'b01001);
                step_exp(1'b1, c, e, (k < 4) ? "R6 early" : "R2 R1 word");
            end
        end

        // R7: overlapping ABAABAAB hits on 5th and 8th
        do_reset();
        begin
            string s = "ABAABAAB";
            for (int k = 0; k < 8; k++)
                step_exp(1'b1, s[k], (k == 4) || (k == 7), "R7 overlap");
        end

        // R3: idle gaps inside a sequence; R4: idle cycles after history matches
        do_reset();
        step_exp(1'b1, 8'h41, 1'b0, "R3 gap");
        step_exp(1'b0, 8'h42, 1'b0, "R4 idle");
        step_exp(1'b1, 8'h42, 1'b0, "R3 gap");
        step_exp(1'b0, 8'h41, 1'b0, "R4 idle");
        step_exp(1'b0, 8'h42, 1'b0, "R4 idle");
        step_exp(1'b1, 8'h41, 1'b0, "R3 gap");
        step_exp(1'b1, 8'h41, 1'b0, "R3 gap");
        step_exp(1'b0, 8'h42, 1'b0, "R4 idle with matching history");
        step_exp(1'b1, 8'h42, 1'b1, "R3 gap completes");

        // R5: partial sequence then reset, finish must not hit
        do_reset();
        step_exp(1'b1, 8'h41, 1'b0, "R5 partial");
        step_exp(1'b1, 8'h42, 1'b0, "R5 partial");
        step_exp(1'b1, 8'h41, 1'b0, "R5 partial");
        step_exp(1'b1, 8'h41, 1'b0, "R5 partial");
        do_reset();
        step_exp(1'b1, 8'h42, 1'b0, "R5 after reset");

        // R8: foreign byte in the window blocks a match until it leaves
        do_reset();
        begin
            string s = "ABaABAAB";
            for (int k = 0; k < 8; k++)
                step_exp(1'b1, s[k], (k == 7), "R8 foreign byte");
        end

        // R9 R2 R4: long mixed stream against the bench model
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = (lfsr[4:0] == 5'd0) ? 8'h61 : (lfsr[7] ? 8'h42 : 8'h41);
            step(lfsr[3:2] != 2'b00, c, "R9 R2 stream");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule